// File: doc/BRIEF.md
# Codec Channel Mode and Power-Down Controller

This block sits beside the digital side of a telephone voice codec and decides, from the activity of its timing inputs, how the channel should run. It watches six pins, all sampled on a fast system clock: the transmit and receive frame syncs, the transmit and receive master clocks, the receive bit-clock pin (which also doubles as a frequency select when it is tied to a level), and the power-down pin. A pin counts as toggling while an edge has been seen within the last `ACT_WINDOW` system cycles. Otherwise it counts as static at its last sampled level.

From these judgements the controller picks one of four channel modes: full duplex, transmit only, receive only or power-down. It drives enables for the two signal paths and a mute for the receive output. It also holds the transmit data driver off until the second transmit frame pulse after wake-up. It reports which master clock should time the channel and whether the transmit bit clock must also serve the receive side. Finally, it gives the master clock frequency the channel expects, in kHz, for the companding law chosen by the `LAW_A` parameter.

Top module: `codec_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (power-down), `tx_en_o`, `rx_en_o` and `dx_oe_o` are 0, and `rx_mute_o` is 1.
- R2: An input is judged toggling for `ACT_WINDOW` system cycles after each edge on it. After that many cycles without an edge, it is judged static at its last level.
- R3: If neither frame sync is toggling, the current mode is held. Once `IDLE_CYCLES` cycles have passed without an edge on either frame sync, the mode becomes 2'b00.
- R4: Once the power-down pin is judged static high, `mode_o` is 2'b00 from the next cycle on, whatever the frame syncs do.
- R5: The channel leaves power-down only when the power-down pin is low or toggling and at least one frame sync is toggling. With both syncs quiet, it stays at 2'b00.
- R6: Transmit sync toggling with receive sync static gives `mode_o` = 2'b01. In this mode `tx_en_o`=1, `rx_en_o`=0 and `rx_mute_o`=1, so receive data is ignored and the receive output sits at zero level.
- R7: Receive sync toggling with transmit sync static gives `mode_o` = 2'b10. In this mode `tx_en_o`=0 and `dx_oe_o`=0.
- R8: Both syncs toggling gives `mode_o` = 2'b11, with `tx_en_o`=1, `rx_en_o`=1 and `rx_mute_o`=0.
- R9: After leaving power-down, `dx_oe_o` stays 0 until the second rising edge of the transmit sync seen while powered up. It follows `tx_en_o` after that, and is 0 in any cycle after a power-down cycle.
- R10: `mclk_rx_sel_o` is 1 (receive master clock) only in mode 2'b10 while the receive master clock is toggling. It is 0 (transmit master clock) otherwise.
- R11: `bclk_shared_o` is 1 when the receive bit-clock pin is static, meaning the transmit bit clock serves both directions. It is 0 while that pin toggles.
- R12: `exp_mclk_khz_o` is set by the law and the select. The select counts as high when the receive bit-clock pin is toggling or static high. For mu-law the output is 1536 when the select is high and 2048 when it is low. For A-law it is 2048 when the select is high and `ALAW_LOW_KHZ` (1536 or 1544) when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| fsx_i | input | 1 | Transmit frame sync, sampled |
| fsr_i | input | 1 | Receive frame sync, sampled |
| mclkx_i | input | 1 | Transmit master clock, sampled |
| mclkr_i | input | 1 | Receive master clock, sampled |
| rbclk_sel_i | input | 1 | Receive bit clock or frequency-select level |
| pdn_i | input | 1 | Power-down pin (high and static forces power-down) |
| mode_o | output | 2 | 00 power-down, 01 transmit only, 10 receive only, 11 full duplex |
| tx_en_o | output | 1 | Transmit path enable |
| rx_en_o | output | 1 | Receive path enable |
| rx_mute_o | output | 1 | Hold receive output at zero level |
| dx_oe_o | output | 1 | Transmit data and time-slot driver enable |
| mclk_rx_sel_o | output | 1 | 1 selects the receive master clock |
| bclk_shared_o | output | 1 | 1 means the transmit bit clock serves receive too |
| exp_mclk_khz_o | output | FREQ_W | Expected master clock frequency in kHz |

## Verification
The assertions assume that every input is already synchronous to `clk` and that a frame sync repeats well within `ACT_WINDOW` cycles. Under that assumption a running channel never looks quiet between two of its own frame pulses. They also assume `IDLE_CYCLES` exceeds `ACT_WINDOW`, so that the timeout can only act after both syncs have been judged static. The stimulus changes inputs on the falling clock edge and sends frame pulses every 16 cycles against a 40-cycle window and a 200-cycle timeout. It starts and stops each pin only between whole pulses, so each edge the controller counts lands at a known cycle.

// File: rtl/codec_mode_pkg.sv
package codec_mode_pkg;
   typedef enum logic [1:0] {
      MODE_OFF = 2'b00,
      MODE_TXO = 2'b01,
      MODE_RXO = 2'b10,
      MODE_DUP = 2'b11
   } chan_mode_t;

   localparam int SRC_FSX = 0;
   localparam int SRC_FSR = 1;
   localparam int SRC_MCX = 2;
   localparam int SRC_MCR = 3;
   localparam int SRC_RBC = 4;
   localparam int SRC_PDN = 5;
   localparam int NSRC    = 6;

   localparam int KHZ_1536 = 1536;
   localparam int KHZ_2048 = 2048;
endpackage

// File: rtl/act_detect.sv
module act_detect #(
   parameter int WINDOW = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic active_o,
   output logic level_o,
   output logic edge_o,
   output logic rise_o
);
   localparam int CW = $clog2(WINDOW + 1);
   localparam logic [CW-1:0] CMAX = CW'(WINDOW);

   logic          prev_q;
   logic [CW-1:0] quiet_q;

   assign edge_o   = sig_i ^ prev_q;
   assign rise_o   = sig_i & ~prev_q;
   assign level_o  = prev_q;
   assign active_o = (quiet_q != CMAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         quiet_q <= CMAX;
      end else begin
         prev_q <= sig_i;
         if (edge_o)
            quiet_q <= '0;
         else if (quiet_q != CMAX)
            quiet_q <= quiet_q + 1'b1;
      end
   end

   // R2
   edge_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> active_o);

   // R2
   quiet_stays_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_o && !active_o) |=> !active_o);
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
   parameter int LIMIT = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_i,
   output logic expired_o
);
   localparam int TW = $clog2(LIMIT + 1);
   localparam logic [TW-1:0] TMAX = TW'(LIMIT);

   logic [TW-1:0] cnt_q;

   assign expired_o = (cnt_q == TMAX);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= TMAX;
      else if (kick_i)
         cnt_q <= '0;
      else if (cnt_q != TMAX)
         cnt_q <= cnt_q + 1'b1;
   end

   // R3
   kick_clears_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick_i |=> !expired_o);

   // R3
   expiry_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && !kick_i) |=> expired_o);
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
   import codec_mode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fsx_act_i,
   input  logic       fsr_act_i,
   input  logic       fsx_rise_i,
   input  logic       pdn_forced_i,
   input  logic       idle_exp_i,
   output chan_mode_t mode_o,
   output logic       dx_ready_o
);
   chan_mode_t mode_q, mode_nxt;
   logic [1:0] wake_q;

   always_comb begin
      mode_nxt = mode_q;
      if (pdn_forced_i)
         mode_nxt = MODE_OFF;
      else if (fsx_act_i && fsr_act_i)
         mode_nxt = MODE_DUP;
      else if (fsx_act_i)
         mode_nxt = MODE_TXO;
      else if (fsr_act_i)
         mode_nxt = MODE_RXO;
      else if (idle_exp_i)
         mode_nxt = MODE_OFF;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_OFF;
         wake_q <= 2'd0;
      end else begin
         mode_q <= mode_nxt;
         if (mode_q == MODE_OFF)
            wake_q <= 2'd0;
         else if (fsx_rise_i && wake_q != 2'd2)
            wake_q <= wake_q + 2'd1;
      end
   end

   assign mode_o     = mode_q;
   assign dx_ready_o = mode_q[0] & (wake_q == 2'd2);

   // R4
   pdn_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pdn_forced_i |=> (mode_q == MODE_OFF));

   // R3
   quiet_holds_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fsx_act_i && !fsr_act_i && !idle_exp_i && !pdn_forced_i) |=> (mode_q == $past(mode_q)));

   // R5
   wake_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_OFF) |=> (mode_q == MODE_OFF) || $past(fsx_act_i || fsr_act_i));

   // R8
   both_syncs_duplex_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn_forced_i && fsx_act_i && fsr_act_i) |=> (mode_q == MODE_DUP));

   // R9
   off_blocks_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_OFF) |=> !dx_ready_o);
endmodule

// File: rtl/codec_mode_ctrl.sv
module codec_mode_ctrl
   import codec_mode_pkg::*;
#(
   parameter int ACT_WINDOW   = 20000,
   parameter int IDLE_CYCLES  = 250000,
   parameter bit LAW_A        = 1'b0,
   parameter int ALAW_LOW_KHZ = 1544,
   parameter int FREQ_W       = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsx_i,
   input  logic              fsr_i,
   input  logic              mclkx_i,
   input  logic              mclkr_i,
   input  logic              rbclk_sel_i,
   input  logic              pdn_i,
   output logic [1:0]        mode_o,
   output logic              tx_en_o,
   output logic              rx_en_o,
   output logic              rx_mute_o,
   output logic              dx_oe_o,
   output logic              mclk_rx_sel_o,
   output logic              bclk_shared_o,
   output logic [FREQ_W-1:0] exp_mclk_khz_o
);
   localparam logic [FREQ_W-1:0] F_1536 = FREQ_W'(KHZ_1536);
   localparam logic [FREQ_W-1:0] F_2048 = FREQ_W'(KHZ_2048);
   localparam logic [FREQ_W-1:0] F_ALOW = FREQ_W'(ALAW_LOW_KHZ);

   if (ACT_WINDOW < 2) begin : g_bad_window
      $error("ACT_WINDOW must be at least 2");
   end
   if (IDLE_CYCLES <= ACT_WINDOW) begin : g_bad_idle
      $error("IDLE_CYCLES must exceed ACT_WINDOW");
   end
   if (ALAW_LOW_KHZ != 1536 && ALAW_LOW_KHZ != 1544) begin : g_bad_alow
      $error("ALAW_LOW_KHZ must be 1536 or 1544");
   end
   if (FREQ_W < 12) begin : g_bad_fw
      $error("FREQ_W must hold 2048");
   end

   logic [NSRC-1:0] pins, act, lvl, edg, rise;

   assign pins = {pdn_i, rbclk_sel_i, mclkr_i, mclkx_i, fsr_i, fsx_i};

   for (genvar g = 0; g < NSRC; g++) begin : g_det
      act_detect #(.WINDOW(ACT_WINDOW)) u_det (
         .clk      (clk),
         .rst_n    (rst_n),
         .sig_i    (pins[g]),
         .active_o (act[g]),
         .level_o  (lvl[g]),
         .edge_o   (edg[g]),
         .rise_o   (rise[g])
      );
   end

   logic pdn_forced, idle_exp, sync_kick, dx_ready, sel_hi;
   chan_mode_t mode;

   assign pdn_forced = ~act[SRC_PDN] & lvl[SRC_PDN];
   assign sync_kick  = edg[SRC_FSX] | edg[SRC_FSR];

   idle_timer #(.LIMIT(IDLE_CYCLES)) u_idle (
      .clk       (clk),
      .rst_n     (rst_n),
      .kick_i    (sync_kick),
      .expired_o (idle_exp)
   );

   mode_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .fsx_act_i    (act[SRC_FSX]),
      .fsr_act_i    (act[SRC_FSR]),
      .fsx_rise_i   (rise[SRC_FSX]),
      .pdn_forced_i (pdn_forced),
      .idle_exp_i   (idle_exp),
      .mode_o       (mode),
      .dx_ready_o   (dx_ready)
   );

   assign mode_o        = mode;
   assign tx_en_o       = mode[0];
   assign rx_en_o       = mode[1];
   assign rx_mute_o     = ~mode[1];
   assign dx_oe_o       = dx_ready;
   assign mclk_rx_sel_o = (mode == MODE_RXO) & act[SRC_MCR];
   assign bclk_shared_o = ~act[SRC_RBC];
   assign sel_hi        = act[SRC_RBC] | lvl[SRC_RBC];

   if (LAW_A) begin : g_law_a
      assign exp_mclk_khz_o = sel_hi ? F_2048 : F_ALOW;
   end else begin : g_law_mu
      assign exp_mclk_khz_o = sel_hi ? F_1536 : F_2048;
   end

   // R12
   freq_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_mclk_khz_o == F_2048) || (exp_mclk_khz_o == (LAW_A ? F_ALOW : F_1536)));

   // R6
   tx_only_mutes_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn_forced && act[SRC_FSX] && !act[SRC_FSR]) |=> (tx_en_o && rx_mute_o));

   // R7
   rx_only_no_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdn_forced && !act[SRC_FSX] && act[SRC_FSR]) |=> (!dx_oe_o && !tx_en_o));
endmodule

// File: tb/codec_mode_ctrl_test.sv
module codec_mode_ctrl_test;
   localparam int WIN  = 40;
   localparam int IDLE = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fsx_i = 0, fsr_i = 0, mclkx_i = 0, mclkr_i = 0, rbclk_sel_i = 0, pdn_i = 0;
   logic fsx_run = 0, fsr_run = 0, mcx_run = 0, mcr_run = 0, rbc_run = 0, rbc_lvl = 0;
   logic pdn_run = 0, pdn_lvl = 0;
   logic [3:0] fcnt = 0;

   logic [1:0]  mode_m, mode_a;
   logic        tx_en, rx_en, rx_mute, dx_oe, mclk_rx_sel, bclk_shared;
   logic        tx_en_a, rx_en_a, rx_mute_a, dx_oe_a, mrs_a, bs_a;
   logic [11:0] khz_mu, khz_a;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   codec_mode_ctrl #(.ACT_WINDOW(WIN), .IDLE_CYCLES(IDLE), .LAW_A(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .fsx_i(fsx_i), .fsr_i(fsr_i), .mclkx_i(mclkx_i),
      .mclkr_i(mclkr_i), .rbclk_sel_i(rbclk_sel_i), .pdn_i(pdn_i), .mode_o(mode_m),
      .tx_en_o(tx_en), .rx_en_o(rx_en), .rx_mute_o(rx_mute), .dx_oe_o(dx_oe),
      .mclk_rx_sel_o(mclk_rx_sel), .bclk_shared_o(bclk_shared), .exp_mclk_khz_o(khz_mu));

   codec_mode_ctrl #(.ACT_WINDOW(WIN), .IDLE_CYCLES(IDLE), .LAW_A(1'b1), .ALAW_LOW_KHZ(1544)) uut_a (
      .clk(clk), .rst_n(rst_n), .fsx_i(fsx_i), .fsr_i(fsr_i), .mclkx_i(mclkx_i),
      .mclkr_i(mclkr_i), .rbclk_sel_i(rbclk_sel_i), .pdn_i(pdn_i), .mode_o(mode_a),
      .tx_en_o(tx_en_a), .rx_en_o(rx_en_a), .rx_mute_o(rx_mute_a), .dx_oe_o(dx_oe_a),
      .mclk_rx_sel_o(mrs_a), .bclk_shared_o(bs_a), .exp_mclk_khz_o(khz_a));

   always @(negedge clk) begin
      fcnt        <= fcnt + 4'd1;
      fsx_i       <= fsx_run && (fcnt == 4'd0);
      fsr_i       <= fsr_run && (fcnt == 4'd0);
      mclkx_i     <= mcx_run ? ~mclkx_i : 1'b0;
      mclkr_i     <= mcr_run ? ~mclkr_i : 1'b0;
      rbclk_sel_i <= rbc_run ? ~rbclk_sel_i : rbc_lvl;
      pdn_i       <= pdn_run ? ~pdn_i : pdn_lvl;
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 mode", mode_m, 0);
      chk("R1 dx_oe", dx_oe, 0);
      chk("R1 rx_mute", rx_mute, 1);
      chk("R1 tx_en", tx_en, 0);
      chk("R1 rx_en", rx_en, 0);
   endtask

   task automatic t_wake_tx;
      int n = 0;
      mcx_run = 1; mcr_run = 1; fsx_run = 1;
      while (mode_m == 2'b00 && n < 100) begin
         @(negedge clk);
         n++;
      end
      chk("R6 mode tx only", mode_m, 1);
      chk("R9 gated at wake", dx_oe, 0);
      wait_n(16);
      chk("R9 gated after first pulse", dx_oe, 0);
      wait_n(16);
      chk("R9 open after second pulse", dx_oe, 1);
      chk("R6 rx_en", rx_en, 0);
      chk("R6 rx_mute", rx_mute, 1);
      chk("R6 tx_en", tx_en, 1);
      chk("R10 tx master clock outside rx mode", mclk_rx_sel, 0);
   endtask

   task automatic t_full;
      fsr_run = 1;
      wait_n(40);
      chk("R8 mode duplex", mode_m, 3);
      chk("R8 rx_en", rx_en, 1);
      chk("R8 rx_mute", rx_mute, 0);
      chk("R8 tx_en", tx_en, 1);
   endtask

   task automatic t_rx;
      fsx_run = 0;
      wait_n(60);
      chk("R7 mode rx only", mode_m, 2);
      chk("R7 tx_en", tx_en, 0);
      chk("R7 dx_oe", dx_oe, 0);
      chk("R10 rx master clock used", mclk_rx_sel, 1);
      mcr_run = 0;
      wait_n(60);
      chk("R10 fallback to tx master clock", mclk_rx_sel, 0);
      fsx_run = 1;
      wait_n(40);
      chk("R8 back to duplex", mode_m, 3);
   endtask

   task automatic t_pdn;
      pdn_lvl = 1;
      wait_n(50);
      chk("R4 forced off", mode_m, 0);
      chk("R4 dx_oe off", dx_oe, 0);
      pdn_lvl = 0; pdn_run = 1;
      wait_n(5);
      chk("R5 wake with toggling pin", mode_m, 3);
      pdn_run = 0; pdn_lvl = 0;
      wait_n(60);
      chk("R5 stay up with pin low", mode_m, 3);
   endtask

   task automatic t_timeout;
      fsx_run = 0; fsr_run = 0;
      wait_n(60);
      chk("R3 hold after syncs static", mode_m, 3);
      wait_n(90);
      chk("R3 hold before timeout", mode_m, 3);
      wait_n(65);
      chk("R3 off after timeout", mode_m, 0);
      wait_n(100);
      chk("R5 no wake without sync", mode_m, 0);
      fsr_run = 1;
      wait_n(20);
      chk("R5 wake on receive sync", mode_m, 2);
   endtask

   task automatic t_bclk;
      rbc_run = 1;
      wait_n(10);
      chk("R11 separate bit clock", bclk_shared, 0);
      chk("R12 mu toggling", khz_mu, 1536);
      chk("R12 A toggling", khz_a, 2048);
      rbc_run = 0; rbc_lvl = 1;
      wait_n(25);
      chk("R2 still active inside window", bclk_shared, 0);
      wait_n(30);
      chk("R11 shared bit clock", bclk_shared, 1);
      chk("R12 mu high", khz_mu, 1536);
      chk("R12 A high", khz_a, 2048);
      rbc_lvl = 0;
      wait_n(50);
      chk("R12 mu low", khz_mu, 2048);
      chk("R12 A low", khz_a, 1544);
      chk("R11 shared bit clock low", bs_a, 1);
   endtask

   initial begin
      wait_n(5);
      rst_n = 1'b1;
      wait_n(2);
      t_reset;
      t_wake_tx;
      t_full;
      t_rx;
      t_pdn;
      t_timeout;
      t_bclk;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule